// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter Stage

This block is one stage of a synchronous binary counter. Every bit of the count register updates on the same rising clock edge. The stage can be preset from a data input through an active-low load. It counts up or down under a direction input, and it steps only while both of its active-low count enables are asserted. Because all bits change together, the output never shows intermediate values, so it can also serve as a clock divider: when counting freely, bit i has a period of 2^(i+1) clocks.

An active-low terminal-count output is decoded from three things: the present count, the direction, and the second ("trickle") enable. The load input does not reach this decode, and neither does the first ("parallel") enable. To build a wider counter, the terminal-count output of each stage drives the trickle enable of the next stage up. All stages share the clock, the load and the parallel enable. No gating is needed between stages, and the chain behaves as one wide up/down counter. A synchronous active-high reset clears the count and gives a known start state.

Top module: `cascade_updown_counter`

## Requirements
- R1: On a rising edge with `rst` high, `q` becomes 0, whatever `load_n`, the enables or `dir_up` are.
- R2: On a rising edge with `rst` low and `load_n` low, `q` takes the value of `din`, whatever `en_p_n`, `en_t_n` and `dir_up` are.
- R3: On a rising edge with `rst` low, `load_n` high, `en_p_n` and `en_t_n` both low and `dir_up` = 1, `q` becomes `q`+1 modulo 2^WIDTH, so 15 wraps to 0.
- R4: Under the same conditions with `dir_up` = 0, `q` becomes `q`-1 modulo 2^WIDTH, so 0 wraps to 15.
- R5: On a rising edge with `rst` low, `load_n` high and either `en_p_n` or `en_t_n` high, `q` keeps its value.
- R6: `tc_n` is 0 exactly when `en_t_n` is 0 and either `dir_up` = 1 with `q` all ones, or `dir_up` = 0 with `q` all zeros. Otherwise it is 1. It is combinational, so it follows a change of `dir_up` or `en_t_n` without waiting for a clock edge.
- R7: `tc_n` does not depend on `en_p_n` or `load_n`. With the count at the terminal value and `en_t_n` low, `tc_n` stays 0 while `en_p_n` is high or `load_n` is low.
- R8: When the stage counts up freely from 0, after n edges bit i of `q` equals bit i of n, so bit 0 divides the clock by 2 and bits 1, 2 and 3 divide it by 4, 8 and 16.
- R9: Three stages chained as described, with stage k+1's `en_t_n` driven by stage k's `tc_n`, behave as one 12-bit counter that loads, holds, counts up and counts down with wrap. The top stage's `tc_n` marks 0xFFF (up) or 0x000 (down).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high clear, highest priority |
| load_n | input | 1 | Active-low synchronous preset from `din` |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| en_p_n | input | 1 | Active-low parallel count enable (not seen by `tc_n`) |
| en_t_n | input | 1 | Active-low trickle count enable, also gates `tc_n` |
| din | input | WIDTH | Preset value |
| q | output | WIDTH | Present count |
| tc_n | output | 1 | Active-low terminal count |

## Verification
A wrong count value shows up on `q` at the first rising edge after the faulty step. Because `q` is the state itself, nothing can hide it. In a chain, a bad carry or borrow decode shows up one edge later, as a higher stage that steps or fails to step. The bench compares the whole 12-bit value against an arithmetic model on every edge, so such a fault is reported in the same cycle it appears. A faulty terminal-count decode shows up on `tc_n` without any clock. The bench therefore samples `tc_n` after each input change, before the next edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_STEP  = 2'd1,
      OP_LOAD  = 2'd2,
      OP_CLEAR = 2'd3
   } cnt_op_e;
endpackage

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
   import cnt_pkg::*;
(
   input  logic    rst,
   input  logic    load_n,
   input  logic    en_p_n,
   input  logic    en_t_n,
   output cnt_op_e op
);
   // fixed priority: clear, then preset, then step when both enables are low
   always_comb begin
      if (rst)                      op = OP_CLEAR;
      else if (!load_n)             op = OP_LOAD;
      else if (!en_p_n && !en_t_n)  op = OP_STEP;
      else                          op = OP_HOLD;
   end
endmodule

// File: rtl/cnt_next.sv
module cnt_next #(
   parameter int WIDTH      = 4,
   parameter int NEXT_STYLE = 1   // 0: adder/subtractor, 1: per-bit toggle chain
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             dir_up,
   output logic [WIDTH-1:0] nxt
);
   if (NEXT_STYLE == 0) begin : g_arith
      assign nxt = dir_up ? cur + WIDTH'(1) : cur - WIDTH'(1);
   end else if (NEXT_STYLE == 1) begin : g_toggle
      // bit i flips when every lower bit already sits at the direction's end value
      logic [WIDTH:0] tgl;
      assign tgl[0] = 1'b1;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign tgl[i+1] = tgl[i] & ~(cur[i] ^ dir_up);
         assign nxt[i]   = cur[i] ^ tgl[i];
      end
   end else begin : g_bad_style
      $error("cnt_next: NEXT_STYLE must be 0 or 1");
   end
endmodule

// File: rtl/cnt_term.sv
module cnt_term #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             dir_up,
   input  logic             en_t_n,
   output logic             tc_n
);
   logic at_end;
   assign at_end = (cur == {WIDTH{dir_up}});
   assign tc_n   = ~(~en_t_n & at_end);
endmodule

// File: rtl/cascade_updown_counter.sv
module cascade_updown_counter
   import cnt_pkg::*;
#(
   parameter int WIDTH      = 4,
   parameter int NEXT_STYLE = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_n,
   input  logic             dir_up,
   input  logic             en_p_n,
   input  logic             en_t_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             tc_n
);
   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

   if (WIDTH < 1) begin : g_bad_width
      $error("cascade_updown_counter: WIDTH must be at least 1");
   end

   cnt_op_e          op;
   logic [WIDTH-1:0] nxt;
   logic [WIDTH-1:0] cnt_q;

   cnt_op_decode u_dec (
      .rst    (rst),
      .load_n (load_n),
      .en_p_n (en_p_n),
      .en_t_n (en_t_n),
      .op     (op)
   );

   cnt_next #(.WIDTH(WIDTH), .NEXT_STYLE(NEXT_STYLE)) u_next (
      .cur    (cnt_q),
      .dir_up (dir_up),
      .nxt    (nxt)
   );

   cnt_term #(.WIDTH(WIDTH)) u_term (
      .cur    (cnt_q),
      .dir_up (dir_up),
      .en_t_n (en_t_n),
      .tc_n   (tc_n)
   );

   always_ff @(posedge clk) begin
      case (op)
         OP_CLEAR: cnt_q <= '0;
         OP_LOAD:  cnt_q <= din;
         OP_STEP:  cnt_q <= nxt;
         default:  cnt_q <= cnt_q;
      endcase
   end

   assign q = cnt_q;

   // R1: the first edge out of reset leaves a zero count
   a_r1_clear: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (q == '0));

   // R2: preset wins over the enables
   a_r2_load: assert property (@(posedge clk) disable iff (rst)
      !load_n |=> (q == $past(din)));

   // R3: up step with wrap
   a_r3_up_step: assert property (@(posedge clk) disable iff (rst)
      (load_n && !en_p_n && !en_t_n && dir_up) |=> (q == $past(q) + WIDTH'(1)));

   // R4: down step with wrap
   a_r4_down_step: assert property (@(posedge clk) disable iff (rst)
      (load_n && !en_p_n && !en_t_n && !dir_up) |=> (q == $past(q) - WIDTH'(1)));

   // R5: any enable high holds the count
   a_r5_hold: assert property (@(posedge clk) disable iff (rst)
      (load_n && (en_p_n || en_t_n)) |=> $stable(q));

   // R6: terminal count only with trickle enable low and the count at its end
   a_r6_tc_gated: assert property (@(posedge clk) disable iff (rst)
      !tc_n |-> (!en_t_n && (dir_up ? (q == ALL_ONES) : (q == '0))));

   // R7: terminal count appears irrespective of the parallel enable and preset
   a_r7_tc_fires: assert property (@(posedge clk) disable iff (rst)
      (!en_t_n && ((dir_up && q == ALL_ONES) || (!dir_up && q == '0))) |-> !tc_n);
endmodule

// File: tb/test_cascade_updown_counter.sv
module test_cascade_updown_counter;
   localparam int W = 4;

   logic        clk = 1'b0;
   logic        rst;
   logic        load_n;
   logic        dir_up;
   logic        en_p_n;
   logic        en_t_n;
   logic [11:0] din12;
   logic [W-1:0] q0, q1, q2;
   logic        tc0, tc1, tc2;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   logic [11:0] model = '0;

   always #4 clk = ~clk;   // 125 MHz

   cascade_updown_counter #(.WIDTH(W)) i_cascade_updown_counter (
      .clk(clk), .rst(rst), .load_n(load_n), .dir_up(dir_up),
      .en_p_n(en_p_n), .en_t_n(en_t_n), .din(din12[3:0]), .q(q0), .tc_n(tc0));

   cascade_updown_counter #(.WIDTH(W), .NEXT_STYLE(0)) i_cascade_updown_counter_mid (
      .clk(clk), .rst(rst), .load_n(load_n), .dir_up(dir_up),
      .en_p_n(en_p_n), .en_t_n(tc0), .din(din12[7:4]), .q(q1), .tc_n(tc1));

   cascade_updown_counter #(.WIDTH(W)) i_cascade_updown_counter_hi (
      .clk(clk), .rst(rst), .load_n(load_n), .dir_up(dir_up),
      .en_p_n(en_p_n), .en_t_n(tc1), .din(din12[11:8]), .q(q2), .tc_n(tc2));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic exp_tc(input logic [11:0] v, input int bits);
      logic [11:0] mask = (12'hFFF >> (12 - bits));
      logic [11:0] endv = dir_up ? mask : 12'h000;
      return !(!en_t_n && ((v & mask) == endv));
   endfunction

   // advance one edge, update the model, then compare the outputs
   task automatic tick(input string req);
      @(posedge clk);
      if (rst)                     model = '0;
      else if (!load_n)            model = din12;
      else if (!en_p_n && !en_t_n) model = dir_up ? model + 12'd1 : model - 12'd1;
      #1;
      check(req, {q2, q1, q0}, model);
   endtask

   task automatic check_tc(input string req);
      #1;
      check({req, " tc low stage"}, tc0, exp_tc(model, 4));
      check({req, " tc chain"}, tc2, exp_tc(model, 12));
   endtask

   initial begin
      rst = 1'b1; load_n = 1'b0; dir_up = 1'b1; en_p_n = 1'b0; en_t_n = 1'b0;
      din12 = 12'hABC;
      // R1: reset beats a pending load
      tick("R1 reset over load");
      tick("R1 reset over load");
      rst = 1'b0; load_n = 1'b1; dir_up = 1'b0;
      check_tc("R6 after reset down");

      // exhaustive stage sweep over value, direction and enables
      for (int v = 0; v < 16; v++) begin
         for (int d = 0; d < 2; d++) begin
            for (int e = 0; e < 4; e++) begin
               load_n = 1'b0; din12 = {8'h5A, 4'(v)};
               dir_up = d[0]; en_p_n = e[0]; en_t_n = e[1];
               tick("R2 load ignores enables");
               load_n = 1'b1;
               check_tc("R6 sweep");
               if (e != 0)        tick("R5 hold");
               else if (d == 1)   tick("R3 up step");
               else               tick("R4 down step");
            end
         end
      end

      // R6: direction change moves tc_n with no edge
      load_n = 1'b0; din12 = 12'hFFF; en_p_n = 1'b1; en_t_n = 1'b1; dir_up = 1'b1;
      tick("R2 load FFF");
      load_n = 1'b1; en_t_n = 1'b0;
      check_tc("R6 up at FFF");
      check("R6 up at FFF tc low", tc2, 1'b0);
      dir_up = 1'b0;
      check_tc("R6 dir flip");
      check("R6 dir flip tc high", tc0, 1'b1);
      dir_up = 1'b1; en_t_n = 1'b1;
      check_tc("R6 trickle high");
      // R7: tc_n ignores en_p_n and load_n
      en_t_n = 1'b0; en_p_n = 1'b1; load_n = 1'b0; din12 = 12'h000;
      #1;
      check("R7 tc low with enp high and load low", tc0, 1'b0);
      check("R7 chain tc low", tc2, 1'b0);
      en_p_n = 1'b0;
      #1;
      check("R7 tc low with load low", tc0, 1'b0);
      tick("R2 load 000");

      // R8: divider behaviour of the low stage
      load_n = 1'b1; dir_up = 1'b1; en_p_n = 1'b0; en_t_n = 1'b0;
      for (int n = 1; n <= 40; n++) begin
         tick("R8 free run");
         for (int i = 0; i < W; i++)
            check($sformatf("R8 bit %0d after %0d edges", i, n), q0[i], (n >> i) & 1);
      end

      // R9: carries and borrows across the chain
      load_n = 1'b0; din12 = 12'hFFD; tick("R9 load FFD");
      load_n = 1'b1; dir_up = 1'b1;
      for (int n = 0; n < 5; n++) begin check_tc("R9 up wrap"); tick("R9 up wrap"); end
      load_n = 1'b0; din12 = 12'h002; tick("R9 load 002");
      load_n = 1'b1; dir_up = 1'b0;
      for (int n = 0; n < 5; n++) begin check_tc("R9 down wrap"); tick("R9 down wrap"); end
      load_n = 1'b0; din12 = 12'h0FF; tick("R9 load 0FF");
      load_n = 1'b1; dir_up = 1'b1; tick("R9 carry into stage 2");
      dir_up = 1'b0; tick("R9 borrow out of stage 2");
      tick("R9 borrow out of stage 2");

      // R9: long pseudo-random mix against the model
      begin
         logic [15:0] lf = 16'hACE1;
         for (int n = 0; n < 6000; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            load_n = (lf[7:3] != 5'd0);
            dir_up = (n / 700) % 2 == 0 ? lf[9] | lf[2] : lf[9] & lf[2];
            en_p_n = (lf[11:10] == 2'b11);
            en_t_n = (lf[14:12] == 3'b111);
            din12  = {lf[3:0], lf[15:8]};
            check_tc("R9 random");
            tick("R9 random");
         end
      end

      // R1: reset while counting
      rst = 1'b1; tick("R1 reset while counting");
      rst = 1'b0;

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule